// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vector Generation

This block keeps a bitmask of pending interrupt requests and, at each instruction boundary, offers the processor one source to service. Three non-maskable sources are examined first in a fixed order: the software trap, then the illegal-opcode trap, then the high-priority pin interrupt, which is gated by the X flag only. When the I flag is clear, the remaining maskable sources are scanned in the order held in a programmable rank table.

The chosen source leaves as a valid/ready offer made of the identifier and the vector fetch address. The processor accepts it by raising `grant_ready_i`. A handshake is a take: it sets the mask flags that the block keeps, clears the pending bit of a non-maskable winner, and starts a fixed overhead window. While that window runs, no offer is made.

Back-pressure rules: while `grant_ready_i` is low, an offer stays pending and may be replaced by a higher-ranked one. The identifier is not held stable. A take happens only in a cycle where both `grant_valid_o` and `grant_ready_i` are high. `grant_ready_i` has no effect while `busy_o` is high.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset the pending mask is empty, `grant_valid_o` and `busy_o` are 0, both `x_mask_o` and `i_mask_o` are 1, and rank table entry k holds source k.
- R2: A one-cycle pulse on bit n of `raise_i` sets pending bit n, and the bit stays set over idle cycles.
- R3: In one update, pending bits named in `grp_clr_i` are removed first, then bits in `grp_set_i` and `raise_i` are added, so a source cleared and not re-set is dropped.
- R4: The software trap (id 14) outranks every source and the illegal-opcode trap (id 13) comes next. Both are offered whatever X and I hold, and a take clears their pending bit.
- R5: The pin interrupt (id 15) is offered after ids 14 and 13, only while X is 0, and a take clears its pending bit.
- R6: While I is 1 no maskable source is offered, and `grant_valid_o` is 0 when no source is eligible.
- R7: Maskable sources are ranked by the table: the first rank index whose entry names a pending maskable source wins. Entries are written through `rank_wr_i`, `rank_idx_i` and `rank_src_i`, and entries naming ids 13–15 are skipped.
- R8: `grant_vec_o` equals the base plus twice `grant_id_o`. The base is 0xFFC0 when `boot_mode_i` is 0 and 0xBFC0 when it is 1.
- R9: A take sets I to 1, and a take of id 15 also sets X to 1. `flag_load_i` loads X and I from `x_i` and `i_i`, and a take in the same cycle overrides the load.
- R10: After a take `busy_o` is 1 for exactly 14 cycles. During that window `grant_valid_o` is 0, `grant_ready_i` is ignored, and new requests are still collected.
- R11: A take of a maskable source leaves its pending bit set. Only a `grp_clr_i` update removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 16 | Per-source request pulses |
| grp_clr_i | input | 16 | Shared-line clear mask, applied before the set bits |
| grp_set_i | input | 16 | Shared-line set mask |
| flag_load_i | input | 1 | Load X and I from x_i and i_i |
| x_i | input | 1 | X value to load |
| i_i | input | 1 | I value to load |
| boot_mode_i | input | 1 | 1 selects the alternate vector base |
| rank_wr_i | input | 1 | Rank table write strobe |
| rank_idx_i | input | 4 | Rank index to write |
| rank_src_i | input | 4 | Source id stored at that rank |
| grant_valid_o | output | 1 | An interrupt is offered |
| grant_ready_i | input | 1 | Processor takes the offer |
| grant_id_o | output | 4 | Offered source id |
| grant_vec_o | output | 16 | Vector fetch address |
| busy_o | output | 1 | Take overhead window active |
| x_mask_o | output | 1 | Current X flag |
| i_mask_o | output | 1 | Current I flag |

## Verification
The check that a taken software trap leaves its pending bit clear assumes the same cycle carries no raise or group-set of that source. The bench never re-raises a source in the cycle it takes it, so this holds. The assertions also take the rank table to hold ids below 16, which is always true at the default width. The stimulus raises and clears shared bits only when no take is in flight, so each expected winner depends on the pending set and the flags alone.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE     = 2'd0,
    SEL_TRAP     = 2'd1,
    SEL_PIN      = 2'd2,
    SEL_MASKABLE = 2'd3
  } sel_kind_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raise_i,
  input  logic [NSRC-1:0] grp_clr_i,
  input  logic [NSRC-1:0] grp_set_i,
  input  logic [NSRC-1:0] take_clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  // clear phase first, then set phase, so stale shared bits vanish
  always_comb begin
    pend_d = pend_q & ~take_clr_i & ~grp_clr_i;
    pend_d = pend_d | grp_set_i | raise_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_rank_table.sv
module irq_rank_table #(
  parameter int NSRC = 16,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [IDW-1:0]            idx_i,
  input  logic [IDW-1:0]            src_i,
  output logic [NSRC-1:0][IDW-1:0]  rank_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_entry
    localparam logic [IDW-1:0] RST_VAL = IDW'(k);
    logic [IDW-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= RST_VAL;
      else if (wr_i && (int'(idx_i) == k))
        ent_q <= src_i;
    end
    assign rank_o[k] = ent_q;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int SWI_ID  = 14,
  parameter int ILL_ID  = 13,
  parameter int PIN_ID  = 15,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]           pend_i,
  input  logic [NSRC-1:0][IDW-1:0]  rank_i,
  input  logic                      x_i,
  input  logic                      i_i,
  output logic                      hit_o,
  output logic [IDW-1:0]            id_o,
  output sel_kind_e                 kind_o
);
  localparam logic [IDW-1:0] SWI_L = IDW'(SWI_ID);
  localparam logic [IDW-1:0] ILL_L = IDW'(ILL_ID);
  localparam logic [IDW-1:0] PIN_L = IDW'(PIN_ID);

  logic           m_hit;
  logic [IDW-1:0] m_id;

  // lowest rank index with a pending maskable source wins
  always_comb begin
    m_hit = 1'b0;
    m_id  = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if ((int'(rank_i[k]) < NSRC) && pend_i[rank_i[k]] &&
          (rank_i[k] != SWI_L) && (rank_i[k] != ILL_L) &&
          (rank_i[k] != PIN_L)) begin
        m_hit = 1'b1;
        m_id  = rank_i[k];
      end
    end
  end

  always_comb begin
    hit_o  = 1'b1;
    id_o   = '0;
    kind_o = SEL_NONE;
    if (pend_i[SWI_ID]) begin
      id_o = SWI_L;  kind_o = SEL_TRAP;
    end else if (pend_i[ILL_ID]) begin
      id_o = ILL_L;  kind_o = SEL_TRAP;
    end else if (pend_i[PIN_ID] && !x_i) begin
      id_o = PIN_L;  kind_o = SEL_PIN;
    end else if (!i_i && m_hit) begin
      id_o = m_id;   kind_o = SEL_MASKABLE;
    end else begin
      hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/irq_busy_timer.sv
module irq_busy_timer #(
  parameter int BUSY_CYCLES = 14,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC        = 16,
  parameter int SWI_ID      = 14,
  parameter int ILL_ID      = 13,
  parameter int PIN_ID      = 15,
  parameter int VEC_W       = 16,
  parameter int BASE_NORMAL = 'hFFC0,
  parameter int BASE_BOOT   = 'hBFC0,
  parameter int BUSY_CYCLES = 14,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  raise_i,
  input  logic [NSRC-1:0]  grp_clr_i,
  input  logic [NSRC-1:0]  grp_set_i,
  input  logic             flag_load_i,
  input  logic             x_i,
  input  logic             i_i,
  input  logic             boot_mode_i,
  input  logic             rank_wr_i,
  input  logic [IDW-1:0]   rank_idx_i,
  input  logic [IDW-1:0]   rank_src_i,
  output logic             grant_valid_o,
  input  logic             grant_ready_i,
  output logic [IDW-1:0]   grant_id_o,
  output logic [VEC_W-1:0] grant_vec_o,
  output logic             busy_o,
  output logic             x_mask_o,
  output logic             i_mask_o
);
  localparam logic [VEC_W-1:0] BASE_N = VEC_W'(BASE_NORMAL);
  localparam logic [VEC_W-1:0] BASE_B = VEC_W'(BASE_BOOT);

  logic [NSRC-1:0]          pend;
  logic [NSRC-1:0][IDW-1:0] rank;
  logic [NSRC-1:0]          take_clr;
  logic                     hit;
  logic [IDW-1:0]           sel_id;
  sel_kind_e                sel_kind;
  logic                     take;
  logic                     x_q, i_q;

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .grp_clr_i(grp_clr_i),
    .grp_set_i(grp_set_i), .take_clr_i(take_clr), .pend_o(pend)
  );

  irq_rank_table #(.NSRC(NSRC)) u_rank (
    .clk(clk), .rst_n(rst_n), .wr_i(rank_wr_i), .idx_i(rank_idx_i),
    .src_i(rank_src_i), .rank_o(rank)
  );

  irq_select #(.NSRC(NSRC), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .PIN_ID(PIN_ID)) u_sel (
    .pend_i(pend), .rank_i(rank), .x_i(x_q), .i_i(i_q),
    .hit_o(hit), .id_o(sel_id), .kind_o(sel_kind)
  );

  irq_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(take), .busy_o(busy_o)
  );

  assign grant_valid_o = hit && !busy_o;
  assign take          = grant_valid_o && grant_ready_i;
  assign grant_id_o    = sel_id;
  assign grant_vec_o   = (boot_mode_i ? BASE_B : BASE_N) +
                         {{(VEC_W-IDW-1){1'b0}}, sel_id, 1'b0};

  // only non-maskable winners are cleared by the arbiter itself
  always_comb begin
    take_clr = '0;
    if (take && (sel_kind != SEL_MASKABLE)) take_clr[sel_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= 1'b1;
      i_q <= 1'b1;
    end else if (take) begin
      i_q <= 1'b1;
      if (sel_kind == SEL_PIN) x_q <= 1'b1;
    end else if (flag_load_i) begin
      x_q <= x_i;
      i_q <= i_i;
    end
  end

  assign x_mask_o = x_q;
  assign i_mask_o = i_q;
endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
  parameter int NSRC   = 16,
  parameter int SWI_ID = 14,
  parameter int ILL_ID = 13,
  parameter int PIN_ID = 15,
  localparam int IDW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] raise_i,
  input logic [NSRC-1:0] grp_set_i,
  input logic [NSRC-1:0] pend,
  input logic            grant_valid_o,
  input logic            grant_ready_i,
  input logic [IDW-1:0]  grant_id_o,
  input logic            busy_o,
  input logic            x_mask_o,
  input logic            i_mask_o
);
  localparam logic [IDW-1:0] SWI_L = IDW'(SWI_ID);
  localparam logic [IDW-1:0] ILL_L = IDW'(ILL_ID);
  localparam logic [IDW-1:0] PIN_L = IDW'(PIN_ID);

  logic take;
  assign take = grant_valid_o && grant_ready_i;

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && pend[SWI_ID]) |-> (grant_id_o == SWI_L)); // R4
  AST_TRAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant_id_o == SWI_L && !raise_i[SWI_ID] && !grp_set_i[SWI_ID])
      |=> !pend[SWI_ID]); // R4
  AST_PIN_NEEDS_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && grant_id_o == PIN_L) |-> !x_mask_o); // R5
  AST_I_BLOCKS_MASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && i_mask_o) |->
      (grant_id_o == SWI_L || grant_id_o == ILL_L || grant_id_o == PIN_L)); // R6
  AST_TAKE_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> i_mask_o); // R9
  AST_PIN_TAKE_SETS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant_id_o == PIN_L) |=> x_mask_o); // R9
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_o); // R10
  AST_NO_OFFER_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !grant_valid_o); // R10
  AST_MASKABLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant_id_o != SWI_L && grant_id_o != ILL_L && grant_id_o != PIN_L)
      |=> pend[$past(grant_id_o)]); // R11
endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(
  .NSRC(NSRC), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .PIN_ID(PIN_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .grp_set_i(grp_set_i),
  .pend(pend), .grant_valid_o(grant_valid_o), .grant_ready_i(grant_ready_i),
  .grant_id_o(grant_id_o), .busy_o(busy_o), .x_mask_o(x_mask_o),
  .i_mask_o(i_mask_o)
);

// File: tb/irq_vec_arbiter_tb.sv
module irq_vec_arbiter_tb;
  localparam int N = 16;
  localparam int SWI = 14, ILL = 13, PIN = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] raise = '0, gclr = '0, gset = '0;
  logic fload = 1'b0, fx = 1'b0, fi = 1'b0, mode = 1'b0;
  logic owr = 1'b0;
  logic [3:0] oidx = '0, osrc = '0;
  logic ready = 1'b0;
  logic valid, busy, xm, im;
  logic [3:0] gid;
  logic [15:0] gvec;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  irq_vec_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .raise_i(raise), .grp_clr_i(gclr), .grp_set_i(gset),
    .flag_load_i(fload), .x_i(fx), .i_i(fi), .boot_mode_i(mode),
    .rank_wr_i(owr), .rank_idx_i(oidx), .rank_src_i(osrc),
    .grant_valid_o(valid), .grant_ready_i(ready), .grant_id_o(gid),
    .grant_vec_o(gvec), .busy_o(busy), .x_mask_o(xm), .i_mask_o(im)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_raise(input logic [N-1:0] v);
    raise = v; nxt(); raise = '0;
  endtask

  task automatic clear_all();
    gclr = '1; nxt(); gclr = '0;
  endtask

  task automatic load_flags(input logic x, input logic i);
    fload = 1'b1; fx = x; fi = i; nxt(); fload = 1'b0;
  endtask

  task automatic take_and_wait();
    ready = 1'b1; nxt(); ready = 1'b0;
    while (busy) nxt();
  endtask

  task automatic set_rank(input int k, input int s);
    owr = 1'b1; oidx = 4'(k); osrc = 4'(s); nxt(); owr = 1'b0;
  endtask

  function automatic bit maskable(input int s);
    return (s != SWI) && (s != ILL) && (s != PIN);
  endfunction

  function automatic int vec_of(input int id, input logic m);
    return (m ? 'hBFC0 : 'hFFC0) + 2 * id;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int bcnt;
    nxt(); nxt();
    rst_n = 1'b1; nxt();
    // R1 reset state
    chk("R1 valid", valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 x", xm, 1);
    chk("R1 i", im, 1);

    load_flags(1'b0, 1'b0);
    // R2 raise and hold
    pulse_raise(N'(1) << 5);
    chk("R2 valid", valid, 1);
    chk("R2 id", gid, 5);
    nxt(); nxt();
    chk("R2 held", gid, 5);
    clear_all();
    chk("R3 all cleared", valid, 0);

    // R7/R8 identity ranking sweep over all maskable pairs
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        if (maskable(a) && maskable(b)) begin
          mode = logic'((a + b) % 2);
          pulse_raise((N'(1) << a) | (N'(1) << b));
          chk("R7 identity order", gid, a);
          chk("R8 vector", gvec, vec_of(a, mode));
          clear_all();
        end
      end
    end
    mode = 1'b0;

    // R3 same-cycle group clear then set
    pulse_raise(N'(1) << 3);
    gclr = (N'(1) << 3) | (N'(1) << 4); gset = N'(1) << 4; nxt();
    gclr = '0; gset = '0;
    chk("R3 stale dropped", gid, 4);
    clear_all();

    // R7 reversed table: rank k holds N-1-k, ids 13..15 must be skipped
    for (int k = 0; k < N; k++) set_rank(k, N - 1 - k);
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        if (maskable(a) && maskable(b)) begin
          pulse_raise((N'(1) << a) | (N'(1) << b) | (N'(1) << PIN));
          load_flags(1'b1, 1'b0);
          chk("R7 reversed order", gid, b);
          clear_all();
        end
      end
    end
    for (int k = 0; k < N; k++) set_rank(k, k);

    // R6 I blocks maskable; R5 pin gated by X
    load_flags(1'b0, 1'b1);
    pulse_raise(N'(1) << 2);
    chk("R6 masked", valid, 0);
    load_flags(1'b1, 1'b0);
    pulse_raise(N'(1) << PIN);
    chk("R5 pin blocked by X", gid, 2);
    load_flags(1'b0, 1'b0);
    chk("R5 pin wins", gid, PIN);
    clear_all();

    // R4 trap ordering ignoring flags, R10 busy window
    load_flags(1'b1, 1'b1);
    pulse_raise((N'(1) << SWI) | (N'(1) << ILL) | (N'(1) << PIN) | (N'(1) << 6));
    chk("R4 swi first", gid, SWI);
    chk("R8 swi vector", gvec, vec_of(SWI, 1'b0));
    ready = 1'b1; nxt();
    bcnt = 0;
    while (busy && bcnt < 40) begin
      chk("R10 no offer while busy", valid, 0);
      bcnt++; nxt();
    end
    ready = 1'b0;
    chk("R10 busy length", bcnt, 14);
    chk("R4 ill next", gid, ILL);
    take_and_wait();
    chk("R4 ill cleared, pin masked", valid, 0);
    load_flags(1'b0, 1'b1);
    chk("R5 pin offered", gid, PIN);
    take_and_wait();
    chk("R9 x set", xm, 1);
    chk("R9 i set", im, 1);
    load_flags(1'b1, 1'b0);
    chk("R5 pin cleared", gid, 6);
    take_and_wait();
    chk("R9 i after maskable", im, 1);
    load_flags(1'b1, 1'b0);
    chk("R11 still pending", gid, 6);

    // R9 take overrides load
    ready = 1'b1; fload = 1'b1; fx = 1'b0; fi = 1'b0; nxt();
    ready = 1'b0; fload = 1'b0;
    chk("R9 take over load", im, 1);
    // R10 ready ignored during busy, new raise collected
    ready = 1'b1;
    pulse_raise(N'(1) << SWI);
    while (busy) nxt();
    ready = 1'b0;
    #1;
    chk("R10 swi collected", gid, SWI);
    chk("R10 swi offered", valid, 1);
    clear_all();
    chk("R11 group clear removes", valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule